// File: doc/BRIEF.md
# Bitfield Deposit Unit

This execution unit packs a bitfield into a 64-bit word. It takes the low-order bits of a source operand, moves them up to a chosen bit position and writes them into a field of a destination word. A 12-bit immediate gives the field's start position and its width. Any realignment of the source must be done by a separate shift before the operands reach the unit.

There are two modes. In insert mode the field is merged into the old destination value, and all other bits keep their previous value. In signed-deposit mode the old destination is not used. The field is sign-extended up to bit 63, and every bit below the field is cleared.

Operands, immediate and mode enter together with a valid bit. One clock later the registered result appears, with its own valid bit. There is no back-pressure, and the unit produces no status flags.

Top module: `bitfield_deposit_unit`

## Requirements
- R1: The immediate carries the field position in bits 11:6 and the width code in bits 5:0. Position 1 with width 10 (immediate 0x04A) affects exactly the bits of mask 0x7FE.
- R2: The field contents are always the least significant bits of `in_src`, moved up so that source bit 0 lands at the field position.
- R3: When `in_signed` is 0 (insert mode), every result bit outside the field equals the matching bit of `in_dst`.
- R4: When `in_signed` is 1 (signed-deposit mode), every result bit above the field equals the field's top bit.
- R5: When `in_signed` is 1, every result bit below the field position is 0, whatever `in_dst` holds.
- R6: A width code of 0 selects a field of 64 bits.
- R7: When position plus width exceeds 64, the field stops at bit 63. No field bit wraps around into the low bits of the word.
- R8: The result and `out_valid` appear exactly one clock after `in_valid` is sampled high. `out_valid` is low one clock after any cycle in which `in_valid` is low or reset is high.
- R9: `out_result` keeps its value in every cycle in which `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks the operands as a valid request |
| in_src | input | 64 | Source operand; the field comes from its low bits |
| in_dst | input | 64 | Old destination value |
| in_imm | input | 12 | Field position in bits 11:6, width code in bits 5:0 |
| in_signed | input | 1 | 0 = insert mode, 1 = signed-deposit mode |
| out_valid | output | 1 | Result valid |
| out_result | output | 64 | Registered result |

## Verification
Each result is due on the first rising edge after its request, so the bench drives a request on a falling edge and reads the outputs on the next falling edge. At that same falling edge it puts the next request in place, which lets the vector table run back to back at one request per cycle. For the directed cases, `in_valid` is dropped for a cycle. The bench then checks that `out_valid` falls one edge later while `out_result` keeps the last value.

// File: rtl/bfd_pkg.sv
package bfd_pkg;
  typedef enum logic {
    BFD_INSERT = 1'b0,
    BFD_SIGNED = 1'b1
  } bfd_mode_e;
endpackage

// File: rtl/bfd_field_mask.sv
// Builds the field, below-field and field-top-bit masks from position and width code.
module bfd_field_mask #(
  parameter int DATA_W = 64,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [IDX_W-1:0]  pos,
  input  logic [IDX_W-1:0]  wcode,
  output logic [DATA_W-1:0] field_mask,
  output logic [DATA_W-1:0] below_mask,
  output logic [DATA_W-1:0] top_mask
);
  localparam logic [IDX_W:0] FULL_LEN = (IDX_W+1)'(DATA_W);

  logic [IDX_W:0]   len;
  logic [DATA_W:0]  ones_ext;
  logic [IDX_W+1:0] top_idx;

  always_comb begin
    // a zero width code means the whole word
    len        = (wcode == '0) ? FULL_LEN : {1'b0, wcode};
    ones_ext   = ({{DATA_W{1'b0}}, 1'b1} << len) - 1'b1;
    // bits shifted past the MSB are dropped: truncation, no wrap
    field_mask = ones_ext[DATA_W-1:0] << pos;
    below_mask = ({{(DATA_W-1){1'b0}}, 1'b1} << pos) - 1'b1;
    top_idx    = {2'b00, pos} + {1'b0, len} - 1'b1;
    if (top_idx < (IDX_W+2)'(DATA_W))
      top_mask = {{(DATA_W-1){1'b0}}, 1'b1} << top_idx[IDX_W-1:0];
    else
      top_mask = '0;
  end
endmodule

// File: rtl/bfd_align.sv
// Moves the low-order source bits up to the field position and keeps only the field.
module bfd_align #(
  parameter int DATA_W = 64,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src,
  input  logic [IDX_W-1:0]  pos,
  input  logic [DATA_W-1:0] field_mask,
  output logic [DATA_W-1:0] aligned
);
  always_comb aligned = (src << pos) & field_mask;
endmodule

// File: rtl/bfd_merge.sv
// Combines the aligned field with the old destination or with the sign fill.
module bfd_merge #(
  parameter int DATA_W = 64
) (
  input  bfd_pkg::bfd_mode_e mode,
  input  logic [DATA_W-1:0]  dst,
  input  logic [DATA_W-1:0]  aligned,
  input  logic [DATA_W-1:0]  field_mask,
  input  logic [DATA_W-1:0]  below_mask,
  input  logic [DATA_W-1:0]  top_mask,
  output logic [DATA_W-1:0]  result
);
  logic              sign_bit;
  logic [DATA_W-1:0] above_mask;

  always_comb begin
    sign_bit   = |(aligned & top_mask);
    above_mask = ~(field_mask | below_mask);
    if (mode == bfd_pkg::BFD_SIGNED)
      result = aligned | (sign_bit ? above_mask : '0);
    else
      result = (dst & ~field_mask) | aligned;
  end
endmodule

// File: rtl/bitfield_deposit_unit.sv
module bitfield_deposit_unit #(
  parameter int DATA_W = 64,
  localparam int IDX_W = $clog2(DATA_W),
  localparam int IMM_W = 2 * IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_src,
  input  logic [DATA_W-1:0] in_dst,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic              in_signed,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result
);
  logic [IDX_W-1:0]   pos;
  logic [IDX_W-1:0]   wcode;
  logic [DATA_W-1:0]  field_mask;
  logic [DATA_W-1:0]  below_mask;
  logic [DATA_W-1:0]  top_mask;
  logic [DATA_W-1:0]  aligned;
  logic [DATA_W-1:0]  result_d;
  bfd_pkg::bfd_mode_e mode;

  // position in the upper half of the immediate, width code in the lower half
  assign pos   = in_imm[IMM_W-1:IDX_W];
  assign wcode = in_imm[IDX_W-1:0];
  assign mode  = in_signed ? bfd_pkg::BFD_SIGNED : bfd_pkg::BFD_INSERT;

  bfd_field_mask #(.DATA_W(DATA_W)) u_mask (
    .pos        (pos),
    .wcode      (wcode),
    .field_mask (field_mask),
    .below_mask (below_mask),
    .top_mask   (top_mask)
  );

  bfd_align #(.DATA_W(DATA_W)) u_align (
    .src        (in_src),
    .pos        (pos),
    .field_mask (field_mask),
    .aligned    (aligned)
  );

  bfd_merge #(.DATA_W(DATA_W)) u_merge (
    .mode       (mode),
    .dst        (in_dst),
    .aligned    (aligned),
    .field_mask (field_mask),
    .below_mask (below_mask),
    .top_mask   (top_mask),
    .result     (result_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_result <= result_d;
    end
  end
endmodule

// File: rtl/bfd_checker.sv
module bfd_checker #(
  parameter int DATA_W = 64,
  localparam int IDX_W = $clog2(DATA_W),
  localparam int IMM_W = 2 * IDX_W
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_src,
  input logic [DATA_W-1:0] in_dst,
  input logic [IMM_W-1:0]  in_imm,
  input logic              in_signed,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_result
);
  logic [DATA_W-1:0] ck_field;
  logic [DATA_W-1:0] ck_below;
  logic [DATA_W-1:0] ck_above;
  logic [DATA_W-1:0] ck_shift;
  logic              ck_sign;

  // bit-by-bit reference masks, built independently of the datapath
  always_comb begin
    int p, n, top;
    p = int'(in_imm[IMM_W-1:IDX_W]);
    n = (in_imm[IDX_W-1:0] == '0) ? DATA_W : int'(in_imm[IDX_W-1:0]);
    top = p + n - 1;
    ck_shift = in_src << in_imm[IMM_W-1:IDX_W];
    ck_sign = (top < DATA_W) ? in_src[n-1] : 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      ck_field[i] = (i >= p) && (i - p < n);
      ck_below[i] = (i < p);
      ck_above[i] = (i > top);
    end
  end

  a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r8_idle_drops_valid: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> !out_valid);
  a_r9_hold_result: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_result));
  a_r2_field_from_lsbs: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (((out_result ^ $past(ck_shift)) & $past(ck_field)) == '0));
  a_r3_insert_keeps_rest: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_signed) |=> (((out_result ^ $past(in_dst)) & ~$past(ck_field)) == '0));
  a_r5_signed_below_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_signed) |=> ((out_result & $past(ck_below)) == '0));
  a_r4_signed_above_fill: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_signed) |=>
      ((out_result & $past(ck_above)) == ($past(ck_sign) ? $past(ck_above) : '0)));
endmodule

bind bitfield_deposit_unit bfd_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_src     (in_src),
  .in_dst     (in_dst),
  .in_imm     (in_imm),
  .in_signed  (in_signed),
  .out_valid  (out_valid),
  .out_result (out_result)
);

// File: tb/bitfield_deposit_unit_tb.sv
module bitfield_deposit_unit_tb;
  localparam int DW = 64;
  localparam int NV = 12;
  localparam int VW = 64 + 64 + 12 + 1 + 64;

  // {src, dst, imm, signed, expected}
  localparam logic [VW-1:0] VEC [NV] = '{
    {64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 12'h04A, 1'b0, 64'h0000_0000_0000_07FE},               // R1
    {64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 12'h04A, 1'b0, 64'hFFFF_FFFF_FFFF_F801},               // R1 R3
    {64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, 12'h208, 1'b0, 64'h1111_1111_1111_F011}, // R2 R3
    {64'h0000_0000_0000_000A, 64'hFFFF_FFFF_FFFF_FFFF, 12'h104, 1'b1, 64'hFFFF_FFFF_FFFF_FFA0}, // R4 R5
    {64'h0000_0000_0000_0005, 64'hFFFF_FFFF_FFFF_FFFF, 12'h104, 1'b1, 64'h0000_0000_0000_0050}, // R4 R5
    {64'hDEAD_BEEF_0123_4567, 64'h0, 12'h000, 1'b0, 64'hDEAD_BEEF_0123_4567},               // R6
    {64'h0000_0000_0000_ABCD, 64'h0000_0000_0000_FFFF, 12'h400, 1'b0, 64'h0000_0000_ABCD_FFFF}, // R6 R7
    {64'h0000_0000_0000_00FF, 64'h0, 12'hF08, 1'b0, 64'hF000_0000_0000_0000},               // R7
    {64'h0000_0000_0000_000F, 64'h0000_0000_0000_00FF, 12'hF08, 1'b1, 64'hF000_0000_0000_0000}, // R7 R5
    {64'h8000_0000_0000_0001, 64'h0, 12'h000, 1'b1, 64'h8000_0000_0000_0001},               // R6 R4
    {64'h0000_0000_0000_0001, 64'h0, 12'h001, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF},               // R4
    {64'h0000_0000_0000_0001, 64'h0, 12'hFC1, 1'b1, 64'h8000_0000_0000_0000}                // R4 R7
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_src = '0;
  logic [DW-1:0] in_dst = '0;
  logic [11:0]   in_imm = '0;
  logic          in_signed = 1'b0;
  logic          out_valid;
  logic [DW-1:0] out_result;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bitfield_deposit_unit #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_src(in_src), .in_dst(in_dst),
    .in_imm(in_imm), .in_signed(in_signed), .out_valid(out_valid), .out_result(out_result)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [VW-1:0] v);
    in_src    = v[VW-1 -: 64];
    in_dst    = v[VW-65 -: 64];
    in_imm    = v[VW-129 -: 12];
    in_signed = v[64];
    in_valid  = 1'b1;
  endtask

  initial begin
    logic [DW-1:0] held;
    repeat (3) @(negedge clk);
    check("R8 reset out_valid", {63'h0, out_valid}, 64'h0);
    in_valid = 1'b1;
    @(negedge clk);
    check("R8 valid held low in reset", {63'h0, out_valid}, 64'h0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);

    // table walk, one request per cycle
    drive(VEC[0]);
    for (int k = 1; k <= NV; k++) begin
      @(negedge clk);
      check($sformatf("R8 valid vec%0d", k-1), {63'h0, out_valid}, 64'h1);
      check($sformatf("R1-R7 table vec%0d", k-1), out_result, VEC[k-1][63:0]);
      if (k < NV) drive(VEC[k]);
      else in_valid = 1'b0;
    end

    // R9: idle cycle, result held, valid drops (R8)
    held = out_result;
    in_src = '1; in_dst = '1; in_imm = 12'h000;
    @(negedge clk);
    check("R8 idle valid", {63'h0, out_valid}, 64'h0);
    check("R9 result held", out_result, held);

    // R3 insert at bit 63 with width 1
    drive({64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 12'hFC1, 1'b0, 64'h0});
    @(negedge clk);
    in_valid = 1'b0;
    check("R3 insert top bit", out_result, 64'h7FFF_FFFF_FFFF_FFFF);

    // R2 only low bits of source used
    drive({64'hFFFF_FFFF_FFFF_FFF0, 64'h0, 12'h084, 1'b0, 64'h0});
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 high source bits ignored", out_result, 64'h0);

    // R8 reset mid-stream
    drive({64'h1, 64'h0, 12'h001, 1'b0, 64'h0});
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    check("R8 reset clears valid", {63'h0, out_valid}, 64'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule